// File: doc/BRIEF.md
# Registered Flagged 8-bit ALU

This block is the arithmetic-logic unit of a small three-register processor. Each cycle it takes an operation code, two 8-bit operands and a carry input. It returns an 8-bit result together with four flags: zero, sign, carry-out and overflow. Twelve operations are supported:

- arithmetic: add, subtract, increment and decrement
- bitwise: AND, OR, XOR and NOT
- movement: shift left, shift right, rotate left and rotate right

All outputs are captured in registers on the falling edge of the system clock. The processor presents operands after a rising edge, and the captured result and flags are then steady when the processor samples them at its following rising edge.

The operation code splits into two fields. Bits [3:2] choose an operation group: arithmetic, bitwise, movement, or unsupported. Bits [1:0] choose the operation inside that group. Codes 12 to 15 are unsupported. For those codes the block drives a zero result with every flag cleared.

Top module: `flag_alu`

## Requirements
- R1: While `rst` is high at a falling clock edge, the result and all four flags are captured as 0.
- R2: Code 0 (add) gives result = A + B + carry_in modulo 256, and carry-out is bit 8 of that sum.
- R3: Code 1 (subtract) gives result = B − A − (1 − carry_in) modulo 256. Carry-out is 1 exactly when that difference is not negative, meaning no borrow occurred.
- R4: Code 2 (increment) gives A + 1 and code 3 (decrement) gives A − 1, both modulo 256. For both codes, carry-out and overflow are 0 and B has no effect.
- R5: Code 4 gives A AND B, code 5 gives A OR B, code 6 gives A XOR B and code 7 gives NOT A. For all four codes, carry-out and overflow are 0.
- R6: Code 8 shifts A left, filling bit 0 with 0 and sending A[7] to carry-out. Code 9 shifts A right, filling bit 7 with 0 and sending A[0] to carry-out. B has no effect on either code.
- R7: Code 10 rotates the 9-bit value {carry_in, A} left: carry_in enters bit 0 and A[7] goes to carry-out. Code 11 rotates it right: carry_in enters bit 7 and A[0] goes to carry-out. B has no effect on either code.
- R8: For codes 0 to 11, the zero flag is 1 exactly when the result is 0x00, and the sign flag equals result bit 7.
- R9: The overflow flag is set only for add and subtract, and only on signed two's-complement overflow of the 8-bit operation. For every other code it is 0.
- R10: Codes 12 to 15 produce a result of 0x00 with the zero, sign, carry and overflow flags all 0.
- R11: The outputs change only at falling edges. Values captured at a falling edge hold through the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the outputs are captured on its falling edge |
| rst | input | 1 | Synchronous active-high reset, sampled at the falling edge |
| op_in | input | 4 | Operation code: bits [3:2] pick the group, bits [1:0] pick the operation |
| a_in | input | 8 | Operand A; the only operand of the single-operand operations |
| b_in | input | 8 | Operand B |
| carry_in | input | 1 | Carry input for add, subtract and the rotates |
| result | output | 8 | Registered result |
| zero_flag | output | 1 | Registered zero flag |
| sign_flag | output | 1 | Registered sign flag |
| carry_flag | output | 1 | Registered carry-out flag |
| ovf_flag | output | 1 | Registered signed-overflow flag |

## Verification
The bench sends every code through corner operands (0x00, 0xFF, 0x7F, 0x80, 0x01, 0x55) with the carry input both 0 and 1, and compares each cycle against a behavioural model. Subtract is the most likely place for errors:

- swapped operands would show up as wrong results;
- an inverted borrow would flip carry-out whenever B ≥ A;
- an unsigned overflow rule would misfire at the 0x7F/0x80 boundary.

Rotates that ignore the carry input, or that take the bit from the wrong end, diverge as soon as carry_in is 1. An unsupported code that still reports zero=1 for its zero result fails the all-cleared rule. Outputs that change on the rising edge are caught by the check made just after each rising edge.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 4;

  // op_in[3:2] selects the group; op_in[1:0] selects the operation inside it
  typedef enum logic [1:0] {
    GRP_ARITH = 2'b00,
    GRP_LOGIC = 2'b01,
    GRP_MOVE  = 2'b10,
    GRP_NONE  = 2'b11
  } alu_grp_e;

  typedef struct packed {
    logic zero;
    logic sign;
    logic carry;
    logic ovf;
  } alu_flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [1:0]       mode,   // 0 add, 1 sub, 2 inc, 3 dec
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] x, y;
  logic             ci;
  logic [WIDTH:0]   full;

  // every mode is folded onto one adder: x + y + ci
  always_comb begin
    case (mode)
      2'd0:    begin x = a; y = b;             ci = cin;  end
      2'd1:    begin x = b; y = ~a;            ci = cin;  end
      2'd2:    begin x = a; y = '0;            ci = 1'b1; end
      default: begin x = a; y = {WIDTH{1'b1}}; ci = 1'b0; end
    endcase
  end

  assign full = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
  assign sum  = full[MSB:0];
  assign cout = full[WIDTH];
  assign ovf  = (x[MSB] == y[MSB]) && (full[MSB] != x[MSB]);
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int WIDTH = 8
) (
  input  logic [1:0]       sel,    // 0 and, 1 or, 2 xor, 3 not
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    case (sel)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = ~a;
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int WIDTH = 8
) (
  input  logic [1:0]       sel,    // 0 shl, 1 shr, 2 rotl through carry, 3 rotr through carry
  input  logic [WIDTH-1:0] a,
  input  logic             cin,
  output logic [WIDTH-1:0] y,
  output logic             cout
);
  localparam int MSB = WIDTH - 1;

  logic fill_lo, fill_hi;

  // shifts fill with 0; rotates fill the vacated bit with the carry input
  assign fill_lo = sel[1] & cin;
  assign fill_hi = sel[1] & cin;

  always_comb begin
    if (sel[0] == 1'b0) begin
      y    = {a[MSB-1:0], fill_lo};
      cout = a[MSB];
    end else begin
      y    = {fill_hi, a[MSB:1]};
      cout = a[0];
    end
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  op_in,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             zero_flag,
  output logic             sign_flag,
  output logic             carry_flag,
  output logic             ovf_flag
);
  localparam int MSB = WIDTH - 1;

  alu_grp_e         grp;
  logic [1:0]       sub;
  logic [WIDTH-1:0] ar_sum, bw_y, sh_y, nxt_res;
  logic             ar_cout, ar_ovf, sh_cout;
  alu_flags_t       nxt_flg;

  assign grp = alu_grp_e'(op_in[3:2]);
  assign sub = op_in[1:0];

  alu_addsub #(.WIDTH(WIDTH)) u_arith (
    .mode(sub), .a(a_in), .b(b_in), .cin(carry_in),
    .sum(ar_sum), .cout(ar_cout), .ovf(ar_ovf)
  );

  alu_bitwise #(.WIDTH(WIDTH)) u_logic (
    .sel(sub), .a(a_in), .b(b_in), .y(bw_y)
  );

  alu_shifter #(.WIDTH(WIDTH)) u_move (
    .sel(sub), .a(a_in), .cin(carry_in), .y(sh_y), .cout(sh_cout)
  );

  always_comb begin
    nxt_res = '0;
    nxt_flg = '0;
    case (grp)
      GRP_ARITH: begin
        nxt_res       = ar_sum;
        // increment/decrement report neither carry nor overflow
        nxt_flg.carry = ~sub[1] & ar_cout;
        nxt_flg.ovf   = ~sub[1] & ar_ovf;
      end
      GRP_LOGIC: nxt_res = bw_y;
      GRP_MOVE: begin
        nxt_res       = sh_y;
        nxt_flg.carry = sh_cout;
      end
      default: ;
    endcase
    if (grp != GRP_NONE) begin
      nxt_flg.zero = (nxt_res == '0);
      nxt_flg.sign = nxt_res[MSB];
    end
  end

  // capture on the falling edge so values are settled at the next rising edge
  always_ff @(negedge clk) begin
    if (rst) begin
      result     <= '0;
      zero_flag  <= 1'b0;
      sign_flag  <= 1'b0;
      carry_flag <= 1'b0;
      ovf_flag   <= 1'b0;
    end else begin
      result     <= nxt_res;
      zero_flag  <= nxt_flg.zero;
      sign_flag  <= nxt_flg.sign;
      carry_flag <= nxt_flg.carry;
      ovf_flag   <= nxt_flg.ovf;
    end
  end

  assert_reset_clear_R1: assert property (@(negedge clk)
    rst |=> (result == '0 && !zero_flag && !sign_flag && !carry_flag && !ovf_flag));

  assert_unsupported_clear_R10: assert property (@(negedge clk) disable iff (rst)
    (op_in >= 4'd12) |=> (result == '0 && !zero_flag && !sign_flag && !carry_flag && !ovf_flag));

  assert_no_overflow_R9: assert property (@(negedge clk) disable iff (rst)
    (op_in >= 4'd2) |=> !ovf_flag);

  assert_zero_sign_R8: assert property (@(negedge clk) disable iff (rst)
    (op_in < 4'd12) |=> (zero_flag == (result == '0) && sign_flag == result[MSB]));

  assert_step_no_carry_R4: assert property (@(negedge clk) disable iff (rst)
    (op_in == 4'd2 || op_in == 4'd3) |=> !carry_flag);
endmodule

// File: tb/flag_alu_bench.sv
module flag_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_in = '0;
  logic [7:0] a_in = '0, b_in = '0;
  logic       carry_in = 1'b0;
  logic [7:0] result;
  logic       zero_flag, sign_flag, carry_flag, ovf_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] e_res;
  logic       e_z, e_s, e_c, e_v;
  bit         have_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_alu u_flag_alu (
    .clk(clk), .rst(rst), .op_in(op_in), .a_in(a_in), .b_in(b_in),
    .carry_in(carry_in), .result(result), .zero_flag(zero_flag),
    .sign_flag(sign_flag), .carry_flag(carry_flag), .ovf_flag(ovf_flag)
  );

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (op %0d a %h b %h c %b)",
               req, act, exp, op_in, a_in, b_in, carry_in);
    end
  endtask

  function automatic string tag_of(int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4, 5, 6, 7: return "R5";
      8, 9: return "R6";
      10, 11: return "R7";
      default: return "R10";
    endcase
  endfunction

  // behavioural reference model
  task automatic model(int op, int a, int b, int c);
    int r, sa, sb, d;
    bit cy, ov;
    cy = 0; ov = 0; r = 0;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    case (op)
      0: begin r = a + b + c; cy = (r > 255); d = sa + sb + c; ov = (d > 127 || d < -128); end
      1: begin r = b - a - (1 - c); cy = (r >= 0); d = sb - sa - (1 - c); ov = (d > 127 || d < -128); end
      2: r = a + 1;
      3: r = a - 1;
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = 255 - a;
      8: begin r = a * 2; cy = (a >= 128); end
      9: begin r = a / 2; cy = a % 2; end
      10: begin r = a * 2 + c; cy = (a >= 128); end
      11: begin r = a / 2 + c * 128; cy = a % 2; end
      default: r = 0;
    endcase
    r = ((r % 256) + 256) % 256;
    e_res = r[7:0];
    e_c = cy;
    e_v = ov;
    e_z = (op < 12) && (r == 0);
    e_s = (op < 12) && (r >= 128);
  endtask

  task automatic apply(int op, int a, int b, int c);
    @(posedge clk);
    #1;
    if (have_prev)  // values captured at the last falling edge are still held
      check("R11", {result, zero_flag, sign_flag, carry_flag, ovf_flag},
                   {e_res, e_z, e_s, e_c, e_v});
    op_in = op[3:0]; a_in = a[7:0]; b_in = b[7:0]; carry_in = c[0];
    model(op, a, b, c);
    @(negedge clk);
    #1;
    check(tag_of(op), {3'b0, result, carry_flag}, {3'b0, e_res, e_c});
    check((op < 12) ? "R8" : "R10", {10'b0, zero_flag, sign_flag}, {10'b0, e_z, e_s});
    check((op < 12) ? "R9" : "R10", {11'b0, ovf_flag}, {11'b0, e_v});
    have_prev = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int avals[6];
    int bvals[3];
    avals = '{8'h00, 8'hFF, 8'h7F, 8'h80, 8'h01, 8'h55};
    bvals = '{8'h00, 8'h80, 8'hFF};
    op_in = 4'd0; a_in = 8'hFF; b_in = 8'hFF; carry_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {4'b0, result}, 12'h0);
    check("R1", {8'b0, zero_flag, sign_flag, carry_flag, ovf_flag}, 12'h0);
    rst = 1'b0;
    for (int op = 0; op < 16; op++)
      for (int ai = 0; ai < 6; ai++)
        for (int bi = 0; bi < 3; bi++)
          for (int c = 0; c < 2; c++)
            apply(op, avals[ai], bvals[bi], c);
    // targeted corners: subtract equality, borrow, signed boundary
    apply(1, 8'h05, 8'h05, 1);
    apply(1, 8'h06, 8'h05, 1);
    apply(1, 8'h01, 8'h80, 1);
    apply(0, 8'h7F, 8'h01, 0);
    apply(10, 8'h80, 8'h00, 0);
    // reset in mid-run clears everything (R1)
    @(posedge clk);
    #1;
    rst = 1'b1; op_in = 4'd0; a_in = 8'hFF; b_in = 8'hFF; carry_in = 1'b1;
    @(negedge clk);
    #1;
    check("R1", {4'b0, result}, 12'h0);
    check("R1", {8'b0, zero_flag, sign_flag, carry_flag, ovf_flag}, 12'h0);
    finish_run();
  end
endmodule